// File: doc/BRIEF.md
# Key-Sequence Armed Watchdog Timer

This block is the recovery timer of a small 8-bit controller core. It listens to the core's special-function-register write bus (write strobe, 8-bit address, 8-bit data) and to a one-clock machine-cycle pulse. It powers up idle. Software arms it by writing a fixed pair of key bytes, in order, to one register address. Software then keeps it quiet by writing the same pair again, often enough to stop a 14-bit cycle counter from wrapping.

Once it is armed, no write can stop the timer. Only a hardware reset, or the timer's own expiry, returns it to the idle state. On expiry the block raises its reset output for a fixed number of clocks. When that pulse ends, the timer is idle again with its count at zero.

Top module: `wdk_top`

## Requirements
- R1: After a reset the block is idle. `wd_rst_out` is low, and no number of machine-cycle pulses makes it rise until the block is armed.
- R2: A write of 0x1E and then a write of 0xE1 to address 0xA6 arms the block. From arming, exactly 2^CNT_W machine-cycle pulses (16384 at the default width) bring it to expiry.
- R3: Expiry is the machine-cycle pulse taken while the count is all ones. `wd_rst_out` goes high on the clock after that pulse and stays high for exactly PULSE_CYC clocks (default 98).
- R4: While armed, the same 0x1E then 0xE1 sequence clears the count. A full 2^CNT_W further pulses are then needed to reach expiry.
- R5: While armed, no write of any value to any address disarms the block or pauses its count.
- R6: The detector keeps only the most recent write to 0xA6. A write of 0xE1 counts only if the write to 0xA6 just before it was 0x1E. Any other value in between cancels the sequence, and a repeated 0x1E keeps it primed.
- R7: Writes to addresses other than 0xA6 neither complete nor cancel a sequence. A key pair written to another address has no effect.
- R8: When the reset pulse ends, the block is idle with a zero count. It stays idle under further machine-cycle pulses until it is armed again.
- R9: A service write of 0xE1 takes effect at the clock edge of its own write cycle. If a machine-cycle pulse arrives in that same cycle, the clear wins, even when the count is all ones.
- R10: A hardware reset (`rst_n` low, sampled on the clock) disarms the block and clears the count.
- R11: Writes made while the reset pulse is high do not change its length and do not re-arm the block. A 0xE1 write with no 0x1E is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | One-clock machine-cycle pulse, active high |
| sfr_we | input | 1 | Register write strobe, active high, one write per clock |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| wd_rst_out | output | 1 | Reset request, high for PULSE_CYC clocks after expiry |

## Verification
The bench builds the block with CNT_W = 5 and PULSE_CYC = 6. Expiry then takes 32 machine cycles, so each test reaches overflow many times within the run. The short width brings within reach the exact overflow boundary, the service pulse that lands on an all-ones count, and a write made in the middle of a pulse. Each of these cases is checked clock by clock against a behavioural model. The key values and the register address are kept at their defaults.

// File: rtl/wdk_pkg.sv
// wdk_pkg: constants and the write-bus record shared by the watchdog parts.
// Assumes one register write per clock at most.
package wdk_pkg;
    localparam logic [7:0] WDK_SVC_ADDR   = 8'hA6;
    localparam logic [7:0] WDK_KEY_FIRST  = 8'h1E;
    localparam logic [7:0] WDK_KEY_SECOND = 8'hE1;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
    } sfr_wr_t;
endpackage

// File: rtl/wdk_keydet.sv
// wdk_keydet: spots the ordered two-byte key pair written to one address.
// Only writes to SVC_ADDR touch its one-bit memory. svc_hit is combinational
// and valid in the cycle of the second key write. flush holds it unprimed.
module wdk_keydet
    import wdk_pkg::*;
#(
    parameter logic [7:0] SVC_ADDR   = WDK_SVC_ADDR,
    parameter logic [7:0] KEY_FIRST  = WDK_KEY_FIRST,
    parameter logic [7:0] KEY_SECOND = WDK_KEY_SECOND
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    flush,
    input  sfr_wr_t wr,
    output logic    svc_hit
);
    logic primed_q;
    logic addr_hit;

    assign addr_hit = wr.we && (wr.addr == SVC_ADDR);

    // Remember whether the last write to the service address was the first key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else if (flush) begin
            primed_q <= 1'b0;
        end else if (addr_hit) begin
            primed_q <= (wr.data == KEY_FIRST);
        end
    end

    // A second-key write that follows a first-key write completes the pair.
    always_comb begin
        svc_hit = addr_hit && primed_q && (wr.data == KEY_SECOND);
    end
endmodule

// File: rtl/wdk_counter.sv
// wdk_counter: free-wrapping machine-cycle counter with a priority clear.
// wrap flags a counted tick taken while all ones. A clear suppresses both.
module wdk_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Advance on each enabled tick, with the clear taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry: a counted tick at the top value that no clear overrides.
    always_comb begin
        wrap = run && tick && !clr && (cnt == CNT_MAX);
    end
endmodule

// File: rtl/wdk_pulse.sv
// wdk_pulse: stretches a one-clock start into LEN clocks of active.
// done marks the last active clock. Assumes LEN >= 1.
module wdk_pulse #(
    parameter int LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int PW = $clog2(LEN + 1);
    localparam logic [PW-1:0] LEN_V = PW'(LEN);

    logic [PW-1:0] left_q;

    // Load the length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LEN_V;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // The pulse is high while clocks remain; done flags the final one.
    always_comb begin
        active = (left_q != '0);
        done   = (left_q == PW'(1));
    end
endmodule

// File: rtl/wdk_top.sv
// wdk_top: key-sequence armed watchdog. It is idle after reset, armed by the
// key pair, serviced by the same pair, and expires after 2^CNT_W machine
// cycles with a PULSE_CYC-clock reset request. Arming is sticky until the
// pulse ends or rst_n is asserted. Assumes mc_tick lasts one clock per cycle.
module wdk_top
    import wdk_pkg::*;
#(
    parameter int         CNT_W      = 14,
    parameter int         PULSE_CYC  = 98,
    parameter logic [7:0] SVC_ADDR   = WDK_SVC_ADDR,
    parameter logic [7:0] KEY_FIRST  = WDK_KEY_FIRST,
    parameter logic [7:0] KEY_SECOND = WDK_KEY_SECOND
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_tick,
    input  logic       sfr_we,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    output logic       wd_rst_out
);
    sfr_wr_t          wr;
    logic             svc_hit;
    logic             svc_take;
    logic             armed_q;
    logic             firing;
    logic             pulse_done;
    logic             ovf;
    logic             cnt_run;
    logic             cnt_clr;
    logic [CNT_W-1:0] wd_cnt;

    // Gather the bus pins into one record.
    always_comb begin
        wr = '{we: sfr_we, addr: sfr_addr, data: sfr_wdata};
    end

    wdk_keydet #(
        .SVC_ADDR  (SVC_ADDR),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) keydet_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (firing),
        .wr     (wr),
        .svc_hit(svc_hit)
    );

    // A completed pair acts only outside the reset pulse; the counter runs while armed.
    always_comb begin
        svc_take = svc_hit && !firing;
        cnt_run  = armed_q && !firing;
        cnt_clr  = svc_take || pulse_done;
    end

    // Sticky enable: set by a key pair, cleared only when the pulse finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (pulse_done) begin
            armed_q <= 1'b0;
        end else if (svc_take) begin
            armed_q <= 1'b1;
        end
    end

    wdk_counter #(
        .W(CNT_W)
    ) counter_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (cnt_run),
        .clr  (cnt_clr),
        .tick (mc_tick),
        .cnt  (wd_cnt),
        .wrap (ovf)
    );

    wdk_pulse #(
        .LEN(PULSE_CYC)
    ) pulse_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ovf),
        .active(firing),
        .done  (pulse_done)
    );

    // The reset request is the stretched pulse.
    always_comb begin
        wd_rst_out = firing;
    end
endmodule

// File: rtl/wdk_chk.sv
// wdk_chk: temporal checks on wdk_top, attached by bind below.
module wdk_chk #(
    parameter int W = 14,
    parameter int P = 98
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mc_tick,
    input logic         rst_out,
    input logic         armed,
    input logic         svc_hit,
    input logic [W-1:0] cnt
);
    int hi_run;

    // Measure the length of the current high run of the reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_run <= 0;
        else if (rst_out) hi_run <= hi_run + 1;
        else hi_run <= 0;
    end

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (hi_run == P));

    // R3
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(mc_tick && armed && (cnt == {W{1'b1}})));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (cnt == '0));

    // R5
    hold_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> $fell(rst_out));

    // R4
    svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_hit && armed && !rst_out) |=> (cnt == '0));

    // R8
    no_fire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !rst_out) |=> !rst_out);
endmodule

bind wdk_top wdk_chk #(.W(CNT_W), .P(PULSE_CYC)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mc_tick(mc_tick),
    .rst_out(wd_rst_out),
    .armed  (armed_q),
    .svc_hit(svc_hit),
    .cnt    (wd_cnt)
);

// File: tb/wdk_top_tb_top.sv
// Bench: a behavioural model is compared with wd_rst_out on every clock,
// alongside scenario checks counting pulses and their length.
module wdk_top_tb_top;
    localparam int CW = 5;
    localparam int PL = 6;
    localparam int FULL = 1 << CW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       wd_rst_out;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // model state
    int  m_cnt = 0;
    int  m_left = 0;
    bit  m_armed = 0;
    bit  m_primed = 0;

    int  rises = 0;
    int  hi_len = 0;
    int  last_len = 0;
    bit  prev_out = 0;

    always #5 clk = ~clk;

    wdk_top #(.CNT_W(CW), .PULSE_CYC(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .sfr_we(sfr_we),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .wd_rst_out(wd_rst_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        bit fire, hit, done, wrap, a_hit;
        if (!rst_n) begin
            m_cnt = 0; m_left = 0; m_armed = 0; m_primed = 0;
        end else begin
            fire  = (m_left != 0);
            done  = (m_left == 1);
            a_hit = sfr_we && (sfr_addr == 8'hA6);
            hit   = a_hit && m_primed && (sfr_wdata == 8'hE1) && !fire;
            wrap  = m_armed && !fire && mc_tick && !hit && (m_cnt == FULL - 1);
            if (fire) m_primed = 0;
            else if (a_hit) m_primed = (sfr_wdata == 8'h1E);
            if (hit || done) m_cnt = 0;
            else if (m_armed && !fire && mc_tick) m_cnt = (m_cnt + 1) % FULL;
            if (done) m_armed = 0;
            else if (hit) m_armed = 1;
            if (wrap) m_left = PL;
            else if (m_left != 0) m_left = m_left - 1;
        end
    end

    // Compare every clock, away from the active edge; track pulse shape.
    always @(negedge clk) begin
        check(wd_rst_out == (m_left != 0), cur_req, int'(wd_rst_out), int'(m_left != 0));
        if (wd_rst_out && !prev_out) rises++;
        if (wd_rst_out) hi_len++;
        else if (prev_out) begin last_len = hi_len; hi_len = 0; end
        prev_out = wd_rst_out;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mc_tick = 0; sfr_we = 0;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sfr_we = 0; mc_tick = 1;
        end
        @(negedge clk);
        mc_tick = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit tk);
        @(negedge clk);
        sfr_we = 1; sfr_addr = a; sfr_wdata = d; mc_tick = tk;
        @(negedge clk);
        sfr_we = 0; mc_tick = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; sfr_we = 0; mc_tick = 0;
        idle(2);
        rst_n = 1;
        idle(1);
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E, 0);
        wr(8'hA6, 8'hE1, 0);
    endtask

    task automatic expect_rises(input int base, input int exp, input string req);
        check(rises - base == exp, req, rises - base, exp);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int b;
        cur_req = "R10";
        do_reset();
        // R1: idle after reset
        cur_req = "R1";
        check(wd_rst_out == 0, "R1", int'(wd_rst_out), 0);
        b = rises; ticks(3 * FULL); idle(2); expect_rises(b, 0, "R1");

        // R11: a lone second key does not arm
        cur_req = "R11";
        b = rises; wr(8'hA6, 8'hE1, 0); ticks(FULL + 4); idle(2); expect_rises(b, 0, "R11");

        // R7: a key pair at another address does nothing
        cur_req = "R7";
        b = rises; wr(8'hA5, 8'h1E, 0); wr(8'hA5, 8'hE1, 0); ticks(FULL + 4); idle(2);
        expect_rises(b, 0, "R7");
        // R7: a foreign write between the keys leaves the sequence intact
        b = rises; wr(8'hA6, 8'h1E, 0); wr(8'h80, 8'h55, 0); wr(8'hA6, 8'hE1, 0);
        ticks(FULL); idle(2); expect_rises(b, 1, "R7");
        idle(PL + 2);
        // R3: pulse length
        check(last_len == PL, "R3", last_len, PL);

        // R8: idle again after the pulse
        cur_req = "R8";
        b = rises; ticks(2 * FULL); idle(2); expect_rises(b, 0, "R8");

        // R6: a wrong value in between cancels; a repeated first key keeps it primed
        cur_req = "R6";
        b = rises; wr(8'hA6, 8'h1E, 0); wr(8'hA6, 8'h00, 0); wr(8'hA6, 8'hE1, 0);
        ticks(FULL + 4); idle(2); expect_rises(b, 0, "R6");
        b = rises; wr(8'hA6, 8'h1E, 0); wr(8'hA6, 8'h1E, 0); wr(8'hA6, 8'hE1, 0);
        // R2: exactly 2^W ticks to expiry
        cur_req = "R2";
        ticks(FULL - 1); idle(2); expect_rises(b, 0, "R2");
        ticks(1); idle(1); expect_rises(b, 1, "R2");
        idle(PL + 2);
        check(last_len == PL, "R3", last_len, PL);

        // R4: service delays expiry
        cur_req = "R4";
        do_reset(); arm();
        b = rises; ticks(20); wr(8'hA6, 8'h1E, 0); wr(8'hA6, 8'hE1, 0);
        ticks(FULL - 1); idle(2); expect_rises(b, 0, "R4");
        ticks(1); idle(PL + 2); expect_rises(b, 1, "R4");

        // R5: no write disarms
        cur_req = "R5";
        do_reset(); arm();
        b = rises;
        wr(8'hA6, 8'h00, 0); wr(8'hA6, 8'hFF, 1); wr(8'hA6, 8'h1E, 1); wr(8'h10, 8'h00, 1);
        ticks(FULL - 3); idle(PL + 2); expect_rises(b, 1, "R5");

        // R9: service on the all-ones tick, clear wins
        cur_req = "R9";
        do_reset(); arm();
        b = rises; ticks(FULL - 1); wr(8'hA6, 8'h1E, 0); wr(8'hA6, 8'hE1, 1);
        idle(3); expect_rises(b, 0, "R9");
        ticks(FULL - 1); idle(2); expect_rises(b, 0, "R9");
        ticks(1); idle(PL + 2); expect_rises(b, 1, "R9");

        // R11: writes during the pulse do not stretch it or re-arm
        cur_req = "R11";
        do_reset(); arm();
        ticks(FULL);
        wr(8'hA6, 8'h1E, 0); wr(8'hA6, 8'hE1, 0);
        idle(PL + 2);
        check(last_len == PL, "R11", last_len, PL);
        b = rises; ticks(FULL + 4); idle(2); expect_rises(b, 0, "R11");

        // R10: hardware reset disarms
        cur_req = "R10";
        do_reset(); arm(); ticks(20);
        do_reset();
        b = rises; ticks(FULL + 8); idle(2); expect_rises(b, 0, "R10");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule